// File: doc/BRIEF.md
# Dataflow Instruction Firing Node

This block is a single execution tile for a grid of dataflow tiles. It holds eight statically placed instructions taken from one atomic block. An instruction does not name source registers. Instead, it names up to two consumer targets, and each target is a (node, slot, operand position) triple. Operands reach the tile as delivery messages, one per cycle, and are latched in per-slot operand buffers.

Once a slot holds everything it needs, the slot becomes ready. Ready slots issue one per cycle, lowest-numbered first, to a single integer ALU. The result is then sent out as one message per valid target over a valid/ready port.

Tests produce a 0/1 result, and a consumer can use that result as its predicate. A slot stays occupied until the block controller pulses `blk_commit`. That pulse empties every slot and drops any unsent result, and only then can a new block's instructions be placed.

Top module: `df_fire_node`

## Requirements
- R1: After reset, `out_valid` and `op_err` are 0, and nothing is sent until an instruction is loaded and its operands are delivered.
- R2: A slot fires once its left operand is present and, except for the unary move (op 5), its right operand is present. Deliveries use `in_pos` 0 for left, 1 for right and 2 for predicate (bit 0 of `in_data`). Position 3 is ignored.
- R3: At most one instruction issues per cycle. Among ready slots, the lowest-numbered one issues first.
- R4: A slot that has fired does not fire again until it is reloaded after a commit.
- R5: The predicate mode is in `ld_instr[4:3]`. Mode 0x means unpredicated. Mode 11 fires only when a predicate of 1 has arrived, and mode 10 fires only when a predicate of 0 has arrived. Otherwise the slot never fires.
- R6: The result is sent first to target 0 (`ld_instr[14:5]`) and then to target 1 (`ld_instr[24:15]`), and a target whose bit 9 is clear is skipped. Within a target, bits 1:0 are the position, bits 4:2 the slot and bits 8:5 the node. These fields appear on `out_pos`, `out_slot` and `out_node`.
- R7: While `out_valid` is high and `out_ready` is low, every output field holds steady and no further slot issues.
- R8: The opcode is in `ld_instr[2:0]`, and the ALU result for each opcode is as follows: 0 gives a+b, 1 gives a−b, 2 gives a&b, 3 gives a|b, 4 gives a^b, 5 passes a, 6 gives 1 if a==b, and 7 gives 1 if a<b signed.
- R9: A delivery to an operand position that is already filled raises `op_err` for one cycle, starting the cycle after the delivery, and the stored value is kept.
- R10: Loading into an occupied slot is ignored. Its instruction, operands and fired state are unchanged.
- R11: `blk_commit` empties all slots, clears all operand flags, drops any unsent result and clears `op_err`. After it, slots accept new instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_commit | input | 1 | Block finished: empty the node |
| ld_valid | input | 1 | Instruction load strobe |
| ld_slot | input | 3 | Slot to load |
| ld_instr | input | 25 | Instruction word |
| in_valid | input | 1 | Operand delivery strobe |
| in_slot | input | 3 | Destination slot of delivery |
| in_pos | input | 2 | Operand position of delivery |
| in_data | input | 32 | Operand value |
| out_valid | output | 1 | Result message valid |
| out_ready | input | 1 | Network accepts message |
| out_node | output | 4 | Consumer node |
| out_slot | output | 3 | Consumer slot |
| out_pos | output | 2 | Consumer operand position |
| out_data | output | 32 | Result value |
| op_err | output | 1 | Duplicate-delivery flag |

## Verification
Operands are delivered in staggered order, so a half-ready binary instruction can be told apart from a complete one. Unary and two-target instructions show the skip and ordering rules. Several slots are made ready behind a stalled output, and their release order shows the lowest-slot priority. Matching and mismatching predicates of both polarities separate the firing rule from a mere arrival check, and a redundant delivery, a reload of a live slot and a commit during a stall each probe state that must survive or vanish.

// File: rtl/df_fire_node.sv
module df_fire_node #(
  parameter int SLOTS  = 8,
  parameter int DW     = 32,
  parameter int NODE_W = 4,
  localparam int SW = $clog2(SLOTS),
  localparam int TW = NODE_W + SW + 3,
  localparam int IW = 5 + 2 * TW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_commit,
  input  logic              ld_valid,
  input  logic [SW-1:0]     ld_slot,
  input  logic [IW-1:0]     ld_instr,
  input  logic              in_valid,
  input  logic [SW-1:0]     in_slot,
  input  logic [1:0]        in_pos,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NODE_W-1:0] out_node,
  output logic [SW-1:0]     out_slot,
  output logic [1:0]        out_pos,
  output logic [DW-1:0]     out_data,
  output logic              op_err
);
  localparam logic [2:0] OP_MOV = 3'd5;

  logic [IW-1:0]    ins [SLOTS];
  logic [DW-1:0]    lop [SLOTS];
  logic [DW-1:0]    rop [SLOTS];
  logic [SLOTS-1:0] occ, done, lv, rv, pv, pb, rdy;
  logic [SW-1:0]    sel;
  logic             fire, dup, ld_ok;
  logic [1:0]       tmask;
  logic [TW-1:0]    tq0, tq1, cur;
  logic [DW-1:0]    res, alu, a_op, b_op;

  for (genvar g = 0; g < SLOTS; g++) begin : g_rdy
    logic [2:0] op;
    logic [1:0] pm;
    assign op = ins[g][2:0];
    assign pm = ins[g][4:3];
    assign rdy[g] = occ[g] & ~done[g] & lv[g] & (rv[g] | (op == OP_MOV)) &
                    (~pm[1] | (pv[g] & (pb[g] == pm[0])));
  end

  always_comb begin
    sel = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (rdy[i]) sel = SW'(i);
  end

  assign fire  = (|rdy) & ~(|tmask);
  assign ld_ok = ld_valid & ~occ[ld_slot];
  assign a_op  = lop[sel];
  assign b_op  = rop[sel];

  always_comb begin
    case (ins[sel][2:0])
      3'd0:    alu = a_op + b_op;
      3'd1:    alu = a_op - b_op;
      3'd2:    alu = a_op & b_op;
      3'd3:    alu = a_op | b_op;
      3'd4:    alu = a_op ^ b_op;
      3'd5:    alu = a_op;
      3'd6:    alu = DW'(a_op == b_op);
      default: alu = DW'($signed(a_op) < $signed(b_op));
    endcase
  end

  always_comb begin
    case (in_pos)
      2'd0:    dup = in_valid & lv[in_slot];
      2'd1:    dup = in_valid & rv[in_slot];
      2'd2:    dup = in_valid & pv[in_slot];
      default: dup = 1'b0;
    endcase
  end

  assign cur       = tmask[0] ? tq0 : tq1;
  assign out_valid = |tmask;
  assign out_pos   = cur[1:0];
  assign out_slot  = cur[SW+1:2];
  assign out_node  = cur[TW-2:SW+2];
  assign out_data  = res;

  always_ff @(posedge clk) begin
    if (ld_ok) ins[ld_slot] <= ld_instr;
    if (in_valid && !dup && in_pos == 2'd0) lop[in_slot] <= in_data;
    if (in_valid && !dup && in_pos == 2'd1) rop[in_slot] <= in_data;
    if (fire) begin
      res <= alu;
      tq0 <= ins[sel][TW+4:5];
      tq1 <= ins[sel][IW-1:TW+5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || blk_commit) begin
      occ <= '0; done <= '0; lv <= '0; rv <= '0; pv <= '0; pb <= '0;
      tmask <= '0;
      op_err <= 1'b0;
    end else begin
      op_err <= dup;
      if (out_valid && out_ready) begin
        if (tmask[0]) tmask[0] <= 1'b0;
        else          tmask[1] <= 1'b0;
      end
      if (fire) begin
        done[sel] <= 1'b1;
        tmask     <= {ins[sel][IW-1], ins[sel][TW+4]};
      end
      if (ld_ok) begin
        occ[ld_slot] <= 1'b1; done[ld_slot] <= 1'b0;
        lv[ld_slot] <= 1'b0; rv[ld_slot] <= 1'b0; pv[ld_slot] <= 1'b0;
      end
      if (in_valid && !dup) begin
        case (in_pos)
          2'd0: lv[in_slot] <= 1'b1;
          2'd1: rv[in_slot] <= 1'b1;
          2'd2: begin pv[in_slot] <= 1'b1; pb[in_slot] <= in_data[0]; end
          default: ;
        endcase
      end
    end
  end

  assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (rdy & ~({SLOTS{1'b1}} << sel)) == '0);
  assert_no_refire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !done[sel]);
  assert_pred_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ins[sel][4] |-> pv[sel] && pb[sel] == ins[sel][3]);
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n || blk_commit)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_node) &&
                                $stable(out_slot) && $stable(out_pos));
  assert_dup_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !blk_commit && in_pos == 2'd0 && lv[in_slot] |=> op_err);
  assert_commit_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blk_commit |=> !out_valid && !op_err);
endmodule

// File: tb/test_df_fire_node.sv
module test_df_fire_node;
  logic clk = 0, rst_n = 0, blk_commit = 0, ld_valid = 0, in_valid = 0, out_ready = 1;
  logic [2:0] ld_slot = 0, in_slot = 0;
  logic [24:0] ld_instr = 0;
  logic [1:0] in_pos = 0;
  logic [31:0] in_data = 0;
  logic out_valid, op_err;
  logic [3:0] out_node;
  logic [2:0] out_slot;
  logic [1:0] out_pos;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  df_fire_node i_df_fire_node (.*);

  typedef struct packed { logic [3:0] n; logic [2:0] s; logic [1:0] p; logic [31:0] d; } msg_t;

  int tests = 0, fails = 0;
  bit fin = 0;
  string cur_req = "R1";
  msg_t mq[$], rx[$];
  logic [24:0] m_ins[8];
  bit m_occ[8], m_done[8], m_lv[8], m_rv[8], m_pv[8], m_pb[8];
  logic [31:0] m_l[8], m_r[8];
  bit m_err;

  function automatic logic [9:0] tg(bit v, int n, int s, int p);
    return {v, 4'(n), 3'(s), 2'(p)};
  endfunction
  function automatic logic [24:0] mk(int op, int pm, logic [9:0] t0, logic [9:0] t1);
    return {t1, t0, 2'(pm), 3'(op)};
  endfunction
  function automatic bit m_ready(int i);
    logic [2:0] op = m_ins[i][2:0];
    logic [1:0] pm = m_ins[i][4:3];
    return m_occ[i] && !m_done[i] && m_lv[i] && (m_rv[i] || op == 3'd5) &&
           (!pm[1] || (m_pv[i] && m_pb[i] == pm[0]));
  endfunction
  function automatic logic [31:0] m_alu(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a;
      6: return {31'b0, a == b};
      default: return {31'b0, $signed(a) < $signed(b)};
    endcase
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n || blk_commit) begin
      for (int i = 0; i < 8; i++) begin
        m_occ[i] = 0; m_done[i] = 0; m_lv[i] = 0; m_rv[i] = 0; m_pv[i] = 0;
      end
      mq.delete();
      m_err = 0;
    end else begin
      automatic int f = -1;
      automatic bit busy = mq.size() != 0;
      automatic bit e = 0;
      if (busy && out_ready) void'(mq.pop_front());
      if (!busy)
        for (int i = 0; i < 8; i++) if (f < 0 && m_ready(i)) f = i;
      if (f >= 0) begin
        automatic logic [31:0] v = m_alu(m_ins[f][2:0], m_l[f], m_r[f]);
        m_done[f] = 1;
        if (m_ins[f][14]) mq.push_back({m_ins[f][13:10], m_ins[f][9:7], m_ins[f][6:5], v});
        if (m_ins[f][24]) mq.push_back({m_ins[f][23:20], m_ins[f][19:17], m_ins[f][16:15], v});
      end
      if (in_valid)
        e = (in_pos == 0 && m_lv[in_slot]) || (in_pos == 1 && m_rv[in_slot]) ||
            (in_pos == 2 && m_pv[in_slot]);
      if (ld_valid && !m_occ[ld_slot]) begin
        m_ins[ld_slot] = ld_instr; m_occ[ld_slot] = 1; m_done[ld_slot] = 0;
        m_lv[ld_slot] = 0; m_rv[ld_slot] = 0; m_pv[ld_slot] = 0;
      end
      if (in_valid && !e) begin
        if (in_pos == 0) begin m_lv[in_slot] = 1; m_l[in_slot] = in_data; end
        if (in_pos == 1) begin m_rv[in_slot] = 1; m_r[in_slot] = in_data; end
        if (in_pos == 2) begin m_pv[in_slot] = 1; m_pb[in_slot] = in_data[0]; end
      end
      m_err = e;
    end
  end

  always @(negedge clk) if (rst_n) begin
    automatic bit ev = mq.size() != 0;
    tests++;
    if (out_valid !== ev || op_err !== m_err) begin
      fails++;
      $display("FAIL %s: valid/err actual %b/%b expected %b/%b", cur_req, out_valid, op_err, ev, m_err);
    end else if (ev && {out_node, out_slot, out_pos, out_data} !== mq[0]) begin
      fails++;
      $display("FAIL %s: message actual %h expected %h", cur_req,
               {out_node, out_slot, out_pos, out_data}, mq[0]);
    end
    if (out_valid && out_ready) rx.push_back({out_node, out_slot, out_pos, out_data});
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic load(int s, logic [24:0] w);
    ld_valid = 1; ld_slot = 3'(s); ld_instr = w; step(); ld_valid = 0;
  endtask
  task automatic put(int s, int p, logic [31:0] d);
    in_valid = 1; in_slot = 3'(s); in_pos = 2'(p); in_data = d; step(); in_valid = 0;
  endtask
  task automatic commit();
    blk_commit = 1; step(); blk_commit = 0;
  endtask
  task automatic expect_rx(string req, int n, int s, int p, logic [31:0] d);
    msg_t exp = {4'(n), 3'(s), 2'(p), d};
    tests++;
    if (rx.size() == 0) begin
      fails++; $display("FAIL %s: no message, expected %h", req, exp);
    end else begin
      msg_t got = rx.pop_front();
      if (got !== exp) begin fails++; $display("FAIL %s: got %h expected %h", req, got, exp); end
    end
  endtask
  task automatic expect_none(string req);
    tests++;
    if (rx.size() != 0) begin
      fails++; $display("FAIL %s: %0d stray messages, expected 0", req, rx.size()); rx.delete();
    end
  endtask
  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(2);
    cur_req = "R1"; expect_none("R1");
    tests++; if (out_valid !== 0 || op_err !== 0) begin
      fails++; $display("FAIL R1: valid/err %b/%b expected 0/0", out_valid, op_err); end

    cur_req = "R2";  // binary add waits for both sides
    load(0, mk(0, 0, tg(1, 3, 5, 0), tg(0, 0, 0, 0)));
    put(0, 0, 7); step(3); expect_none("R2");
    put(0, 1, 5); step(3); expect_rx("R8", 3, 5, 0, 12);
    load(1, mk(5, 0, tg(1, 2, 1, 1), tg(0, 0, 0, 0)));
    put(1, 0, 32'hAB); step(3); expect_rx("R2", 2, 1, 1, 32'hAB);

    cur_req = "R7";  // two targets behind a stall
    load(2, mk(1, 0, tg(1, 4, 0, 0), tg(1, 6, 7, 2)));
    out_ready = 0; put(2, 0, 10); put(2, 1, 3); step(6); expect_none("R7");
    cur_req = "R6"; out_ready = 1; step(3);
    expect_rx("R6", 4, 0, 0, 7); expect_rx("R6", 6, 7, 2, 7);

    cur_req = "R3";  // several ready behind a pending result
    out_ready = 0;
    load(3, mk(5, 0, tg(1, 1, 3, 0), tg(0, 0, 0, 0))); put(3, 0, 1);
    load(6, mk(5, 0, tg(1, 1, 6, 0), tg(0, 0, 0, 0)));
    load(4, mk(5, 0, tg(1, 1, 4, 0), tg(0, 0, 0, 0)));
    put(6, 0, 66); put(4, 0, 44); step(2);
    out_ready = 1; step(8);
    expect_rx("R3", 1, 3, 0, 1); expect_rx("R3", 1, 4, 0, 44); expect_rx("R3", 1, 6, 0, 66);

    cur_req = "R5";  // true-polarity slot, predicate never matches
    load(5, mk(6, 3, tg(1, 9, 0, 2), tg(0, 0, 0, 0)));
    put(5, 0, 5); put(5, 1, 5); step(3); expect_none("R5");
    put(5, 2, 0); step(3); expect_none("R5");
    load(7, mk(7, 2, tg(1, 9, 1, 0), tg(0, 0, 0, 0)));
    put(7, 0, 32'hFFFF_FFFF); put(7, 1, 2); put(7, 2, 0); step(3);
    expect_rx("R8", 9, 1, 0, 1);

    cur_req = "R9";
    put(0, 0, 99);
    tests++; if (op_err !== 1) begin fails++; $display("FAIL R9: op_err %b expected 1", op_err); end
    step(); tests++; if (op_err !== 0) begin fails++; $display("FAIL R9: op_err %b expected 0", op_err); end

    cur_req = "R10";  // reload of live slot 5 must not reopen it
    load(5, mk(5, 0, tg(1, 8, 8, 0), tg(0, 0, 0, 0)));
    put(5, 0, 9); step(3); expect_none("R10");

    cur_req = "R11";
    commit();
    out_ready = 0;
    load(0, mk(5, 0, tg(1, 2, 2, 0), tg(0, 0, 0, 0))); put(0, 0, 5); step(2);
    commit();
    tests++; if (out_valid !== 0) begin fails++; $display("FAIL R11: out_valid %b expected 0", out_valid); end
    out_ready = 1; step(3); expect_none("R11");

    cur_req = "R9";  // ignored duplicate keeps first value, reload after commit works
    load(0, mk(0, 0, tg(1, 3, 3, 0), tg(0, 0, 0, 0)));
    put(0, 0, 1); put(0, 0, 100); put(0, 1, 2); step(3);
    expect_rx("R9", 3, 3, 0, 3);
    expect_none("R4");

    fin = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fails++; tests++;
      $display("FAIL %s: watchdog expired, actual hang expected finish", cur_req);
      summary();
      $finish;
    end
  end
endmodule